// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous static memory whose data phase always lags its command by two clock cycles, for reads and writes alike. Because both kinds of transfer sit at the same distance from their command, a read may follow a write, or a write a read, in the very next cycle with no idle slot on the data path. It serves either as an on-chip memory or as a memory model inside a larger testbench.

Every input is sampled on the rising clock edge. A command cycle either loads a fresh address, which requires all three chip selects to be active, or advances a four-beat burst that was opened by an earlier load. The burst walks the two low address bits in interleaved or linear order. Write data is taken per byte lane under active-low lane selects. Read data leaves through a registered port together with a valid flag. An active-low clock enable freezes the whole pipeline, including its outputs, for as long as it is held high.

Top module: `zt_sram`

## Requirements
- R1: A read command sampled at a rising edge with the clock enable low (`clkEnN`=0), `advLoad`=0 (0 = load, 1 = advance), `wrEnN`=1 and all chip selects active (`selAN`=0, `selB`=1, `selCN`=0) drives `rdValid`=1 and the stored word on `rdData` right after the second enabled edge that follows. `rdValid` is 0 in every other cycle.
- R2: A selected load with `wrEnN`=0 is a write. The word on `wrData` at the second enabled edge after the command is the value stored.
- R3: Reads and writes may be issued in consecutive cycles in any mix with no idle cycle between them. A read issued one cycle after a write to the same address returns the newly written word.
- R4: While `clkEnN`=1, every input is ignored and `rdData`, `rdValid`, the pipeline and the burst state keep their values. Operation resumes where it stopped once `clkEnN` returns to 0.
- R5: A load cycle (`advLoad`=0) in which any chip select is inactive starts no transfer and ends any open burst, so later advance cycles do nothing. Transfers already in the pipeline still complete.
- R6: With `burstLinear`=0 sampled at the burst load, beat k (k=0..3) of a burst uses low address bits equal to start[1:0] XOR k.
- R7: With `burstLinear`=1 sampled at the burst load, beat k uses low address bits equal to (start[1:0] + k) mod 4. The upper address bits stay those of the load in both orders.
- R8: An advance cycle (`advLoad`=1) inside an open burst ignores the chip selects, `wrEnN`, `laneWrN` and `addr`. It repeats the read/write type and lane choice latched at the load.
- R9: On a write, lane i (bits [8i+7:8i] at the default 8-bit lane width) is updated only when `laneWrN[i]`=0. With all `laneWrN` bits low the full word is written.
- R10: After reset `rdValid` is 0 and no burst is open, so an advance cycle performs no transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all inputs sampled on rising edge |
| rstN | input | 1 | Active-low synchronous reset of pipeline and burst state |
| clkEnN | input | 1 | Active-low clock enable; high stalls everything |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| advLoad | input | 1 | 0 = load a new address, 1 = advance the burst |
| wrEnN | input | 1 | Active-low write enable, sampled on load cycles |
| laneWrN | input | LANES | Active-low per-lane write selects, sampled on load cycles |
| burstLinear | input | 1 | Burst order at load: 1 = linear, 0 = interleaved |
| addr | input | ADDR_W | Word address, sampled on load cycles |
| wrData | input | LANES*LANE_W | Write data, sampled two enabled edges after the command |
| rdData | output | LANES*LANE_W | Registered read data |
| rdValid | output | 1 | High for the cycle carrying read data |

## Verification
The bound checker watches the port-level timing on every cycle. It confirms that a selected read yields `rdValid` exactly two enabled edges later, that a deselecting load leaves that slot empty, and that a high clock enable freezes `rdData` and `rdValid`. The directed scenarios cover what depends on memory contents: write data alignment, byte-lane masking, read-after-write with no gap, and the interleaved and linear beat orders. They also show that latched burst attributes override the advance-cycle inputs and that a deselect ends a burst while letting in-flight beats finish.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burstOrd_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic advance;   // pipeline clock enable for this edge
    logic doWrite;   // oldest stage holds a write
    logic doRead;    // oldest stage holds a read
  } dpStrobe_t;

  function automatic logic [1:0] burstOffset(input logic [1:0] startBits,
                                             input logic [1:0] beat,
                                             input burstOrd_e  ord);
    return (ord == ORD_LINEAR) ? (startBits + beat) : (startBits ^ beat);
  endfunction

endpackage

// File: rtl/zt_burst.sv
module zt_burst
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              startBurst,
  input  logic              stopBurst,
  input  logic              advBurst,
  input  logic [ADDR_W-1:0] baseIn,
  input  burstOrd_e         ordIn,
  output logic              burstActive,
  output logic [ADDR_W-1:0] advAddr
);

  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beatCnt;
  logic [1:0]        nextCnt;
  burstOrd_e         ordQ;

  always_comb begin
    nextCnt = beatCnt + 2'd1;
    advAddr = {baseAddr[ADDR_W-1:2], burstOffset(baseAddr[1:0], nextCnt, ordQ)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      baseAddr    <= '0;
      beatCnt     <= '0;
      ordQ        <= ORD_INTERLEAVE;
    end else if (stepEn) begin
      if (startBurst) begin
        burstActive <= 1'b1;
        baseAddr    <= baseIn;
        beatCnt     <= '0;
        ordQ        <= ordIn;
      end else if (stopBurst) begin
        burstActive <= 1'b0;
      end else if (advBurst && burstActive) begin
        beatCnt <= nextCnt;
      end
    end
  end

endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              advLoad,
  input  logic              wrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstLinear,
  input  logic [ADDR_W-1:0] addr,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] opAddr,
  output logic [LANES-1:0]  opLanes
);

  logic stepEn, chipSel, startOp, stopOp, advOp;
  logic burstActive;
  logic [ADDR_W-1:0] advAddr;

  // attributes latched at burst load
  logic             burstWrite;
  logic [LANES-1:0] burstLanes;

  // command issued this cycle
  logic              issueValid, issueWrite;
  logic [ADDR_W-1:0] issueAddr;
  logic [LANES-1:0]  issueLanes;

  // two pipeline stages
  logic              s1Valid, s1Write, s2Valid, s2Write;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Lanes, s2Lanes;

  always_comb begin
    stepEn  = !clkEnN;
    chipSel = !selAN && selB && !selCN;
    startOp = !advLoad && chipSel;
    stopOp  = !advLoad && !chipSel;
    advOp   = advLoad && burstActive;
  end

  zt_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .startBurst (startOp),
    .stopBurst  (stopOp),
    .advBurst   (advLoad),
    .baseIn     (addr),
    .ordIn      (burstOrd_e'(burstLinear)),
    .burstActive(burstActive),
    .advAddr    (advAddr)
  );

  always_comb begin
    issueValid = startOp || advOp;
    issueWrite = startOp ? !wrEnN : burstWrite;
    issueAddr  = startOp ? addr : advAddr;
    issueLanes = startOp ? ~laneWrN : burstLanes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstWrite <= 1'b0;
      burstLanes <= '0;
    end else if (stepEn && startOp) begin
      burstWrite <= !wrEnN;
      burstLanes <= ~laneWrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
      s1Addr  <= '0;
      s1Lanes <= '0;
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
      s2Addr  <= '0;
      s2Lanes <= '0;
    end else if (stepEn) begin
      s1Valid <= issueValid;
      s1Write <= issueWrite;
      s1Addr  <= issueAddr;
      s1Lanes <= issueLanes;
      s2Valid <= s1Valid;
      s2Write <= s1Write;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
    end
  end

  always_comb begin
    strobe.advance = stepEn;
    strobe.doWrite = s2Valid && s2Write;
    strobe.doRead  = s2Valid && !s2Write;
    opAddr         = s2Addr;
    opLanes        = s2Lanes;
  end

endmodule

// File: rtl/zt_datapath.sv
module zt_datapath
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES-1:0]        opLanes,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] readWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.advance && strobe.doWrite && opLanes[g])
        laneMem[opAddr] <= wrData[g*LANE_W +: LANE_W];
    end

    assign readWord[g*LANE_W +: LANE_W] = laneMem[opAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else if (strobe.advance) begin
      rdValid <= strobe.doRead;
      if (strobe.doRead) rdData <= readWord;
    end
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              advLoad,
  input  logic              wrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstLinear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] opAddr;
  logic [LANES-1:0]  opLanes;

  zt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEnN     (clkEnN),
    .selAN      (selAN),
    .selB       (selB),
    .selCN      (selCN),
    .advLoad    (advLoad),
    .wrEnN      (wrEnN),
    .laneWrN    (laneWrN),
    .burstLinear(burstLinear),
    .addr       (addr),
    .strobe     (strobe),
    .opAddr     (opAddr),
    .opLanes    (opLanes)
  );

  zt_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opAddr (opAddr),
    .opLanes(opLanes),
    .wrData (wrData),
    .rdData (rdData),
    .rdValid(rdValid)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    clkEnN,
  input logic                    selAN,
  input logic                    selB,
  input logic                    selCN,
  input logic                    advLoad,
  input logic                    wrEnN,
  input logic [LANES*LANE_W-1:0] rdData,
  input logic                    rdValid
);

  logic selAll;
  assign selAll = !selAN && selB && !selCN;

  // R1: selected read shows up after two further enabled edges
  p_read_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLoad && selAll && wrEnN) ##1 !clkEnN ##1 !clkEnN |=> rdValid);

  // R5: deselecting load leaves its data slot empty
  p_deselect_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLoad && !selAll) ##1 !clkEnN ##1 !clkEnN |=> !rdValid);

  // R4: stalled edge holds the outputs
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(rdValid) && $stable(rdData)));

  // R4: valid can only rise across an enabled edge
  p_rise_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(!clkEnN));

endmodule

bind zt_sram zt_sram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;

  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 8;
  localparam int DW = LN * LW;
  localparam logic [2:0] SEL  = 3'b010;  // {selAN, selB, selCN} all active
  localparam logic [2:0] DESA = 3'b110;  // selAN inactive
  localparam logic [2:0] DESB = 3'b000;  // selB inactive
  localparam logic [2:0] DESC = 3'b011;  // selCN inactive
  localparam logic [LN-1:0] ALL = '0;
  localparam logic [LN-1:0] NONE = '1;

  logic clk = 1'b0;
  logic rstN, clkEnN, selAN, selB, selCN, advLoad, wrEnN, burstLinear;
  logic [LN-1:0] laneWrN;
  logic [AW-1:0] addr;
  logic [DW-1:0] wrData, rdData;
  logic rdValid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (.*);

  function automatic logic [DW-1:0] dv(input int k);
    return 32'hB000_0000 + DW'(k);
  endfunction

  task automatic step(input logic ld, input logic [2:0] ce, input logic wr,
                      input logic [LN-1:0] ln, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd);
    advLoad = ld;
    {selAN, selB, selCN} = ce;
    wrEnN = !wr;
    laneWrN = ln;
    addr = a;
    wrData = wd;
    @(negedge clk);
  endtask

  task automatic idle(input logic [DW-1:0] wd);
    step(1'b0, DESA, 1'b0, NONE, '0, wd);
  endtask

  task automatic chkV(input string req, input logic exp);
    checks++;
    if (rdValid !== exp) begin
      errors++;
      $display("FAIL %s rdValid act=%0b exp=%0b", req, rdValid, exp);
    end
  endtask

  task automatic chkD(input string req, input logic [DW-1:0] exp);
    checks++;
    if (rdValid !== 1'b1 || rdData !== exp) begin
      errors++;
      $display("FAIL %s rdValid=%0b rdData act=%h exp=%h", req, rdValid, rdData, exp);
    end
  endtask

  task automatic t_reset;
    chkV("R10 reset", 1'b0);
    step(1'b1, SEL, 1'b0, ALL, 8'h05, '0);   // advance with no open burst
    idle('0);
    chkV("R10 no-burst advance", 1'b0);
    idle('0);
    chkV("R10 no-burst advance", 1'b0);
  endtask

  task automatic t_write_read;
    step(1'b0, SEL, 1'b1, ALL, 8'h10, '0);
    idle('0);
    idle(32'hCAFE_0110);                       // data for the write
    chkV("R2 write gives no read", 1'b0);
    step(1'b0, SEL, 1'b0, ALL, 8'h10, '0);
    chkV("R1 not early", 1'b0);
    idle('0);
    chkV("R1 not early", 1'b0);
    idle('0);
    chkD("R1 R2 read back", 32'hCAFE_0110);
    idle('0);
    chkV("R1 single pulse", 1'b0);
  endtask

  task automatic t_back_to_back;
    step(1'b0, SEL, 1'b1, ALL, 8'h20, '0);
    step(1'b0, SEL, 1'b0, ALL, 8'h20, '0);
    step(1'b0, SEL, 1'b1, ALL, 8'h21, 32'h1111_2020);
    chkV("R3 write slot", 1'b0);
    step(1'b0, SEL, 1'b0, ALL, 8'h21, '0);
    chkD("R3 read after write", 32'h1111_2020);
    idle(32'h2222_2121);
    chkV("R3 write slot", 1'b0);
    idle('0);
    chkD("R3 read after write", 32'h2222_2121);
  endtask

  task automatic t_lanes;
    step(1'b0, SEL, 1'b1, ALL, 8'h30, '0);
    idle('0);
    idle(32'h1122_3344);
    step(1'b0, SEL, 1'b1, 4'b1010, 8'h30, '0); // lanes 0 and 2 only
    idle('0);
    idle(32'hAABB_CCDD);
    step(1'b0, SEL, 1'b0, ALL, 8'h30, '0);
    idle('0);
    idle('0);
    chkD("R9 lane mask", 32'h11BB_33DD);
  endtask

  task automatic t_stall;
    step(1'b0, SEL, 1'b0, ALL, 8'h30, '0);
    clkEnN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, SEL, 1'b1, ALL, 8'h30, 32'hDEAD_BEEF);
      chkV("R4 stall", 1'b0);
    end
    clkEnN = 1'b0;
    idle('0);
    chkV("R4 resume", 1'b0);
    idle('0);
    chkD("R4 resume data, stalled write ignored", 32'h11BB_33DD);
    clkEnN = 1'b1;
    idle('0);
    idle('0);
    chkD("R4 output hold", 32'h11BB_33DD);
    clkEnN = 1'b0;
    idle('0);
    chkV("R4 after hold", 1'b0);
  endtask

  // Interleaved write burst from 0x42: 42,43,40,41. Advance cycles carry
  // read type, no lanes and deselects, all of which must be ignored.
  task automatic t_burst_write;
    burstLinear = 1'b0;
    step(1'b0, SEL, 1'b1, ALL, 8'h42, '0);
    step(1'b1, DESB, 1'b0, NONE, 8'hFF, '0);
    step(1'b1, DESC, 1'b0, NONE, 8'hFF, dv(0));
    chkV("R8 burst stays write", 1'b0);
    step(1'b1, DESA, 1'b0, NONE, 8'hFF, dv(1));
    chkV("R8 burst stays write", 1'b0);
    idle(dv(2));
    idle(dv(3));
    step(1'b0, SEL, 1'b0, ALL, 8'h42, '0);
    step(1'b0, SEL, 1'b0, ALL, 8'h43, '0);
    step(1'b0, SEL, 1'b0, ALL, 8'h40, '0);
    chkD("R6 R8 beat0 at 42", dv(0));
    step(1'b0, SEL, 1'b0, ALL, 8'h41, '0);
    chkD("R6 R8 beat1 at 43", dv(1));
    idle('0);
    chkD("R6 R8 beat2 at 40", dv(2));
    idle('0);
    chkD("R6 R8 beat3 at 41", dv(3));
  endtask

  // mem: 40=d2 41=d3 42=d0 43=d1
  task automatic t_burst_read(input logic lin);
    logic [DW-1:0] e [4];
    if (lin) e = '{dv(3), dv(0), dv(1), dv(2)};
    else     e = '{dv(3), dv(2), dv(1), dv(0)};
    burstLinear = lin;
    step(1'b0, SEL, 1'b0, ALL, 8'h41, '0);
    burstLinear = !lin;                        // only the load sample counts
    step(1'b1, SEL, 1'b0, ALL, 8'h00, '0);
    step(1'b1, SEL, 1'b0, ALL, 8'h00, '0);
    chkD(lin ? "R7 linear beat0" : "R6 interleaved beat0", e[0]);
    step(1'b1, SEL, 1'b0, ALL, 8'h00, '0);
    chkD(lin ? "R7 linear beat1" : "R6 interleaved beat1", e[1]);
    idle('0);
    chkD(lin ? "R7 linear beat2" : "R6 interleaved beat2", e[2]);
    idle('0);
    chkD(lin ? "R7 linear beat3" : "R6 interleaved beat3", e[3]);
  endtask

  task automatic t_deselect;
    burstLinear = 1'b0;
    step(1'b0, SEL, 1'b0, ALL, 8'h41, '0);
    step(1'b1, SEL, 1'b0, ALL, 8'h00, '0);
    step(1'b0, DESC, 1'b0, ALL, 8'h42, '0);   // deselect load
    chkD("R5 in-flight beat0", dv(3));
    step(1'b1, SEL, 1'b0, ALL, 8'h00, '0);   // advance after stop
    chkD("R5 in-flight beat1", dv(2));
    idle('0);
    chkV("R5 deselect slot empty", 1'b0);
    idle('0);
    chkV("R5 burst ended", 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    clkEnN = 1'b0;
    burstLinear = 1'b0;
    advLoad = 1'b0;
    {selAN, selB, selCN} = DESA;
    wrEnN = 1'b1;
    laneWrN = NONE;
    addr = '0;
    wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_write_read();
    t_back_to_back();
    t_lanes();
    t_stall();
    t_burst_write();
    t_burst_read(1'b0);
    t_burst_read(1'b1);
    t_deselect();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule